// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous binary up-counter with a parallel preset, an asynchronous clear and two count enables. Every state bit is updated from the same rising clock edge, so the outputs move together and never show intermediate values from bit-to-bit rippling. The default width is four bits, and the width is a parameter.

The block has two enables. `cnt_en` only allows counting. `chain_en` also allows counting, and in addition it gates the terminal-count flag `carry_out`. Several stages can therefore be chained into a wider counter without extra logic:

- `cnt_en` is shared by all stages.
- Each higher stage takes its `chain_en` from the `carry_out` of the stage below it.

A preset takes priority over both enables. The clear takes priority over everything and does not wait for a clock edge.

Top module: `bin_counter_casc`

## Requirements
- R1: Driving `zero_n` low sets `count` to all zeros at once, without waiting for a clock edge. This holds whatever the levels of `clk`, `preset_n`, `cnt_en` and `chain_en`.
- R2: When `zero_n` is high and `preset_n` is low at a rising edge, `count` takes the value of `preset_val` on that edge. This holds whatever the levels of `cnt_en` and `chain_en`.
- R3: When `zero_n` and `preset_n` are both high at a rising edge, `count` increases by one if `cnt_en` and `chain_en` are both high. Otherwise `count` keeps its value.
- R4: `carry_out` is high exactly while `chain_en` is high and `count` is all ones (15 for the default width). It follows `chain_en` combinationally between clock edges.
- R5: Counting from all ones gives zero on the next edge. For example, a preset to 12 followed by counting gives 13, 14, 15, 0, 1 and 2.
- R6: A change on `preset_n`, `cnt_en` or `chain_en` between clock edges leaves `count` unchanged. Only the levels present at a rising edge select preset, count or hold.
- R7: While `zero_n` is low, `count` stays at zero across rising edges, even when `preset_n` is low or both enables are high.
- R8: Two instances can be chained into a counter twice as wide. The low stage has `chain_en` tied high, the high stage takes `chain_en` from the low stage's `carry_out`, and `cnt_en` is shared. The high stage advances only on the edge where the low stage wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| zero_n | input | 1 | Asynchronous clear, active low |
| preset_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable; does not affect the carry |
| chain_en | input | 1 | Count enable that also gates `carry_out` |
| preset_val | input | WIDTH | Value loaded on a preset |
| count | output | WIDTH | Counter state |
| carry_out | output | 1 | Terminal-count flag, gated by `chain_en` |

## Verification
Two pairs of functions can fall in the same cycle.

- **Preset and counting.** The bench drives `preset_n` low while both enables are high, including when `count` is all ones. The check is that the preset value wins and that no wrap or increment appears.
- **Clear and pending preset.** The bench drives `zero_n` low midway between edges while a preset is pending. It checks that `count` reads zero before the next edge, and that it stays zero through that edge rather than taking the preset value.

// File: rtl/bctr_pkg.sv
package bctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_PRESET = 2'd1,
    OP_INCR   = 2'd2
  } bctr_op_t;

  // Priority: preset first, then counting (needs both enables), else hold.
  function automatic bctr_op_t pick_op(input logic preset_n,
                                       input logic cnt_en,
                                       input logic chain_en);
    if (!preset_n)               return OP_PRESET;
    else if (cnt_en && chain_en) return OP_INCR;
    else                         return OP_HOLD;
  endfunction
endpackage

// File: rtl/bctr_ctrl.sv
module bctr_ctrl
  import bctr_pkg::*;
(
  input  logic     preset_n,
  input  logic     cnt_en,
  input  logic     chain_en,
  output bctr_op_t op,
  output logic     load_evt,
  output logic     incr_evt
);
  always_comb begin
    op       = pick_op(preset_n, cnt_en, chain_en);
    load_evt = (op == OP_PRESET);
    incr_evt = (op == OP_INCR);
  end
endmodule

// File: rtl/bctr_state.sv
module bctr_state
  import bctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             zero_n,
  input  bctr_op_t         op,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  function automatic logic [WIDTH-1:0] next_q(input bctr_op_t o,
                                              input logic [WIDTH-1:0] cur,
                                              input logic [WIDTH-1:0] d);
    case (o)
      OP_PRESET: return d;
      OP_INCR:   return cur + ONE;  // natural modulo wrap
      default:   return cur;
    endcase
  endfunction

  // All bits share one clock edge; clear enters via async branch.
  always_ff @(posedge clk or negedge zero_n) begin
    if (!zero_n) q <= '0;
    else         q <= next_q(op, q, preset_val);
  end
endmodule

// File: rtl/bctr_carry.sv
module bctr_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             chain_en,
  output logic             at_top,
  output logic             carry
);
  logic [WIDTH-1:0] ones_upto;

  // Per-bit AND chain: ones_upto[i] means bits 0..i are all one.
  assign ones_upto[0] = q[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign ones_upto[i] = ones_upto[i-1] & q[i];
  end

  assign at_top = ones_upto[WIDTH-1];
  assign carry  = at_top & chain_en;
endmodule

// File: rtl/bin_counter_casc.sv
module bin_counter_casc
  import bctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             zero_n,
  input  logic             preset_n,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  bctr_op_t op;
  logic     load_evt;
  logic     incr_evt;
  logic     at_top;

  bctr_ctrl u_ctrl (
    .preset_n (preset_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op),
    .load_evt (load_evt),
    .incr_evt (incr_evt)
  );

  bctr_state #(.WIDTH(WIDTH)) u_state (
    .clk        (clk),
    .zero_n     (zero_n),
    .op         (op),
    .preset_val (preset_val),
    .q          (count)
  );

  bctr_carry #(.WIDTH(WIDTH)) u_carry (
    .q        (count),
    .chain_en (chain_en),
    .at_top   (at_top),
    .carry    (carry_out)
  );
endmodule

// File: rtl/bin_counter_casc_chk.sv
module bin_counter_casc_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             zero_n,
  input logic             preset_n,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] count,
  input logic             carry_out,
  input logic             load_evt,
  input logic             incr_evt
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R1 / R7: while clear is low, state reads zero at every edge
  a_r7_clear_holds: assert property (@(posedge clk) !zero_n |-> count == '0);

  // R2: preset captures the data regardless of enables
  a_r2_preset: assert property (@(posedge clk) disable iff (!zero_n)
    !preset_n |=> count == $past(preset_val));

  // R3 / R5: increment by one, wrapping
  a_r3_incr: assert property (@(posedge clk) disable iff (!zero_n)
    incr_evt |=> count == WIDTH'($past(count) + 1'b1));

  // R3: no preset and not both enables -> hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!zero_n)
    (preset_n && !(cnt_en && chain_en)) |=> $stable(count));

  // R4: carry only at top with chain enable
  a_r4_carry_top: assert property (@(posedge clk) disable iff (!zero_n)
    carry_out |-> (chain_en && count == TOP));
  a_r4_carry_gate: assert property (@(posedge clk) disable iff (!zero_n)
    !chain_en |-> !carry_out);

  // R2: preset and increment never selected together
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!zero_n)
    $countones({load_evt, incr_evt}) <= 1);
endmodule

bind bin_counter_casc bin_counter_casc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .zero_n     (zero_n),
  .preset_n   (preset_n),
  .cnt_en     (cnt_en),
  .chain_en   (chain_en),
  .preset_val (preset_val),
  .count      (count),
  .carry_out  (carry_out),
  .load_evt   (load_evt),
  .incr_evt   (incr_evt)
);

// File: tb/bin_counter_casc_tb_top.sv
`timescale 1ns/1ps
module bin_counter_casc_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         zero_n, preset_n, cnt_en, chain_en;
  logic [W-1:0] preset_val;
  logic [W-1:0] count;
  logic         carry_out;

  // cascade pair
  logic         c_preset_n, c_cnt_en;
  logic [W-1:0] c_lo_val, c_hi_val, lo_q, hi_q;
  logic         lo_carry, hi_carry;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bin_counter_casc #(.WIDTH(W)) dut_i (
    .clk(clk), .zero_n(zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .preset_val(preset_val), .count(count),
    .carry_out(carry_out));

  bin_counter_casc #(.WIDTH(W)) lo_i (
    .clk(clk), .zero_n(zero_n), .preset_n(c_preset_n), .cnt_en(c_cnt_en),
    .chain_en(1'b1), .preset_val(c_lo_val), .count(lo_q),
    .carry_out(lo_carry));

  bin_counter_casc #(.WIDTH(W)) hi_i (
    .clk(clk), .zero_n(zero_n), .preset_n(c_preset_n), .cnt_en(c_cnt_en),
    .chain_en(lo_carry), .preset_val(c_hi_val), .count(hi_q),
    .carry_out(hi_carry));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive after the falling edge, then let one rising edge pass and sample 1 ns later
  task automatic step(input bit p_n, input bit e, input bit c, input int d);
    @(negedge clk);
    preset_n = p_n; cnt_en = e; chain_en = c; preset_val = W'(d);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    zero_n = 0; preset_n = 1; cnt_en = 0; chain_en = 0; preset_val = '0;
    c_preset_n = 1; c_cnt_en = 0; c_lo_val = '0; c_hi_val = '0;
    #1;
    chk("R1 reset state", count, 0);
    repeat (3) @(negedge clk);
    zero_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", count, 0);
  endtask

  task automatic t_preset_run;
    int exp_seq[6] = '{13, 14, 15, 0, 1, 2};
    step(0, 0, 0, 12);
    chk("R2 preset 12", count, 12);
    foreach (exp_seq[i]) begin
      step(1, 1, 1, 0);
      chk("R5 count sequence", count, exp_seq[i]);
    end
    step(1, 0, 1, 0);
    chk("R3 hold when cnt_en low", count, 2);
  endtask

  task automatic t_truth_table;
    for (int start = 0; start < 16; start += 5) begin
      for (int combo = 0; combo < 8; combo++) begin
        bit p_n = combo[2];
        bit e   = combo[1];
        bit c   = combo[0];
        int exp;
        step(0, 0, 0, start);                // set start value
        if (!p_n)        exp = (start + 9) % 16;
        else if (e && c) exp = (start + 1) % 16;
        else             exp = start;
        step(p_n, e, c, (start + 9) % 16);
        chk(p_n ? "R3 count/hold table" : "R2 preset over enables", count, exp);
        #0.5;
        chk("R4 carry", carry_out, (c && exp == 15) ? 1 : 0);
      end
    end
  endtask

  task automatic t_preset_vs_count_at_top;
    step(0, 1, 1, 15);
    step(0, 1, 1, 6);     // preset wins while at all ones with both enables
    chk("R2 preset beats increment at top", count, 6);
  endtask

  task automatic t_carry_comb;
    step(0, 0, 0, 15);
    @(negedge clk); preset_n = 1; cnt_en = 0; chain_en = 1; #0.5;
    chk("R4 carry high at top", carry_out, 1);
    chain_en = 0; #0.5;
    chk("R4 carry follows chain_en", carry_out, 0);
    chain_en = 1; #0.5;
    chk("R4 carry returns", carry_out, 1);
    @(posedge clk); #1;
    chk("R3 hold at top, cnt_en low", count, 15);
  endtask

  task automatic t_between_edges;
    step(0, 0, 0, 4);
    @(negedge clk); preset_n = 0; preset_val = 11; cnt_en = 1; chain_en = 1; #1;
    chk("R6 preset_n mid-cycle no effect", count, 4);
    preset_n = 1; cnt_en = 0; #1;
    chk("R6 enables mid-cycle no effect", count, 4);
    @(posedge clk); #1;
    chk("R6 edge-level decides (hold)", count, 4);
  endtask

  task automatic t_async_clear;
    step(0, 0, 0, 9);
    @(negedge clk); preset_n = 0; preset_val = 7; cnt_en = 1; chain_en = 1;
    @(posedge clk); #1;   // loads 7
    chk("R2 load 7", count, 7);
    #0.5 zero_n = 0; #0.5;
    chk("R1 clear mid-cycle", count, 0);
    @(posedge clk); #1;
    chk("R7 clear beats preset", count, 0);
    @(negedge clk); zero_n = 1; preset_n = 1;
    @(posedge clk); #1;
    chk("R3 count after clear", count, 1);
  endtask

  task automatic t_cascade;
    int exp;
    @(negedge clk); c_preset_n = 0; c_lo_val = 4'd13; c_hi_val = 4'd3; c_cnt_en = 1;
    @(posedge clk); #1;
    exp = 3 * 16 + 13;
    chk("R8 cascade preset", {hi_q, lo_q}, exp);
    @(negedge clk); c_preset_n = 1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      exp = (exp + 1) % 256;
      chk("R8 cascade count", {hi_q, lo_q}, exp);
    end
    @(negedge clk); c_cnt_en = 0;
    @(posedge clk); #1;
    chk("R8 cascade hold", {hi_q, lo_q}, exp);
  endtask

  initial begin
    t_reset();
    t_preset_run();
    t_truth_table();
    t_preset_vs_count_at_top();
    t_carry_comb();
    t_between_edges();
    t_async_clear();
    t_cascade();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule